// File: doc/BRIEF.md
# Contact-Gap Voltage Tracking Arrester Controller

This block sets how many series arrester cells of a hybrid dc breaker are switched into the fault path while the mechanical disconnector is still opening. On each control tick it derives the present contact gap from a measured contact position and turns that gap into a withstand voltage. It then rounds that voltage to the nearest whole number of cells, using the per-cell voltage estimate it is given. The voltage-tracking count only ever grows during the opening stroke, so the voltage across the contacts climbs with the gap.

A separate current-regulation loop supplies its own requested count. The block drives the smaller of the two. Once the voltage side has asked for every cell, the block hands control over to the current loop for good, and the requested count then passes straight through. Before a trip, and whenever the trip flag is low at a tick, no cell is inserted and the mode output reports idle. State changes only on the cycle where the update strobe (nominally 10 kHz, one per 100 µs) is high.

Top module: `arr_vtrack_ctl`

## Requirements
- R1: After reset, `cells_o` is 0 and `mode_o` is 0 (idle).
- R2: On a tick with `trip_i` low, `cells_o` becomes 0 and `mode_o` becomes 0 on the following clock edge, whatever the other inputs are.
- R3: Gap in µm = 2 × `pos_i` − `OVERLAP_UM`; a gap at or below zero is taken as zero and gives a voltage count of 0.
- R4: The withstand reference in volts is gap(µm) × `BRK_V_PER_MM` / 1000 × `MARGIN_NUM` / `MARGIN_DEN`. The voltage count is this reference divided by `cell_v_i` (in volts), rounded to nearest with an exact half rounding up.
- R5: Neither the voltage count nor `cells_o` ever exceeds `NCELL`.
- R6: While in voltage mode, `cells_o` is the minimum of the voltage count and `ireq_i`; an `ireq_i` above `NCELL` counts as `NCELL`.
- R7: The voltage count held in voltage mode never decreases, even if the measured gap shrinks.
- R8: `mode_o` codes are 0 idle, 1 voltage, 2 current. The first tick with trip high enters 1, or 2 directly if the voltage count already equals `NCELL`. The tick on which the voltage count reaches `NCELL` enters 2. Mode 2 is kept while trip stays high, and in it `cells_o` follows the saturated `ireq_i`.
- R9: Without a tick, `cells_o` and `mode_o` hold their values whatever the other inputs do.
- R10: A per-cell estimate of 0 V gives a voltage count of `NCELL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Update strobe, one cycle per control period |
| trip_i | input | 1 | Trip command from protection |
| pos_i | input | POS_W | Position of one moving contact, µm |
| cell_v_i | input | CV_W | Estimated voltage of one inserted cell, V |
| ireq_i | input | CNT_W | Cell count requested by the current loop |
| cells_o | output | CNT_W | Number of cells to insert |
| mode_o | output | 2 | 0 idle, 1 voltage tracking, 2 current regulation |

## Verification
The held voltage count cannot be read directly. With the current request saturated, it shows on `cells_o` one clock after each tick. A wrong held value shows up either as a count that falls when the gap shrinks or as a count that stays below the rounded gap voltage. A mode register that is stuck or misdecoded shows at once on `mode_o`. It can also show one tick later as a count that ignores `ireq_i` in current mode, or that ignores the gap in voltage mode. Exact rounding points, the clamped gap and the zero-estimate case are driven at their edges, because an off-by-one in the comparator bank moves the count by exactly one cell at those points.

// File: rtl/arr_ctl_pkg.sv
package arr_ctl_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_VOLT = 2'd1,
        MODE_CURR = 2'd2
    } mode_e;

endpackage

// File: rtl/arr_sep_calc.sv
// Contact gap from one contact's absolute position: two contacts move
// symmetrically, minus the overlap they keep when closed. Negative -> 0.
module arr_sep_calc #(
    parameter int POS_W      = 12,
    parameter int OVERLAP_UM = 1000,
    parameter int SEP_W      = POS_W + 1
) (
    input  logic [POS_W-1:0] pos_i,
    output logic [SEP_W-1:0] sep_o
);

    localparam int DW = SEP_W + 2;

    logic signed [DW-1:0] twice_s;
    logic signed [DW-1:0] diff_s;

    always_comb begin
        twice_s = $signed({2'b00, pos_i, 1'b0});
        diff_s  = twice_s - $signed(DW'(OVERLAP_UM));
        if (diff_s <= 0) begin
            sep_o = '0;
        end else begin
            sep_o = diff_s[SEP_W-1:0];
        end
    end

endmodule

// File: rtl/arr_level_quant.sv
// Nearest-level quantizer. Level k (1..NCELL) is reached when
// Vref >= (k - 1/2) * Vcell, written without division as
//   2*gap*BRK*NUM  >=  (2k-1) * Vcell * 1000 * DEN.
// The comparator outputs form a thermometer code; the count of set
// bits is the rounded level, capped at NCELL by construction.
module arr_level_quant #(
    parameter int NCELL        = 8,
    parameter int SEP_W        = 13,
    parameter int CV_W         = 16,
    parameter int CNT_W        = 4,
    parameter int BRK_V_PER_MM = 500,
    parameter int MARGIN_NUM   = 4,
    parameter int MARGIN_DEN   = 5
) (
    input  logic [SEP_W-1:0] sep_i,
    input  logic [CV_W-1:0]  cell_v_i,
    output logic [CNT_W-1:0] level_o
);

    localparam int MW    = 64;
    localparam int LHS_K = 2 * BRK_V_PER_MM * MARGIN_NUM;
    localparam int RHS_K = 1000 * MARGIN_DEN;

    logic [MW-1:0]    lhs;
    logic [MW-1:0]    rhs_unit;
    logic [NCELL-1:0] hit;

    always_comb begin
        lhs      = MW'(sep_i) * MW'(LHS_K);
        rhs_unit = MW'(cell_v_i) * MW'(RHS_K);
    end

    for (genvar k = 1; k <= NCELL; k++) begin : g_lvl
        localparam logic [MW-1:0] ODD = MW'(2 * k - 1);
        logic [MW-1:0] thr;
        always_comb begin
            thr        = ODD * rhs_unit;
            hit[k-1]   = (lhs >= thr);
        end
    end

    always_comb begin
        level_o = CNT_W'($countones(hit));
    end

endmodule

// File: rtl/arr_min_merge.sv
// Saturates the current-loop request at NCELL and selects the smaller
// of it and the voltage-side count.
module arr_min_merge #(
    parameter int NCELL = 8,
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] vcnt_i,
    input  logic [CNT_W-1:0] ireq_i,
    output logic [CNT_W-1:0] ireq_sat_o,
    output logic [CNT_W-1:0] min_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(NCELL);

    always_comb begin
        ireq_sat_o = (ireq_i > FULL) ? FULL : ireq_i;
        min_o      = (vcnt_i < ireq_sat_o) ? vcnt_i : ireq_sat_o;
    end

endmodule

// File: rtl/arr_vtrack_ctl.sv
module arr_vtrack_ctl
    import arr_ctl_pkg::*;
#(
    parameter int NCELL        = 8,
    parameter int POS_W        = 12,
    parameter int CV_W         = 16,
    parameter int OVERLAP_UM   = 1000,
    parameter int BRK_V_PER_MM = 500,
    parameter int MARGIN_NUM   = 4,
    parameter int MARGIN_DEN   = 5,
    localparam int CNT_W       = $clog2(NCELL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             trip_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [CV_W-1:0]  cell_v_i,
    input  logic [CNT_W-1:0] ireq_i,
    output logic [CNT_W-1:0] cells_o,
    output logic [1:0]       mode_o
);

    localparam int SEP_W = POS_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NCELL);

    typedef struct packed {
        logic [CNT_W-1:0] vt;
        logic [CNT_W-1:0] cnt;
        mode_e            mode;
    } state_t;

    state_t st_q, st_d;

    logic [SEP_W-1:0] sep;
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] vt_max;
    logic [CNT_W-1:0] ireq_sat;
    logic [CNT_W-1:0] merged;

    arr_sep_calc #(
        .POS_W     (POS_W),
        .OVERLAP_UM(OVERLAP_UM),
        .SEP_W     (SEP_W)
    ) u_sep (
        .pos_i(pos_i),
        .sep_o(sep)
    );

    arr_level_quant #(
        .NCELL       (NCELL),
        .SEP_W       (SEP_W),
        .CV_W        (CV_W),
        .CNT_W       (CNT_W),
        .BRK_V_PER_MM(BRK_V_PER_MM),
        .MARGIN_NUM  (MARGIN_NUM),
        .MARGIN_DEN  (MARGIN_DEN)
    ) u_quant (
        .sep_i   (sep),
        .cell_v_i(cell_v_i),
        .level_o (level)
    );

    // Voltage-side count only ratchets upward during the stroke.
    always_comb begin
        vt_max = (st_q.vt > level) ? st_q.vt : level;
    end

    arr_min_merge #(
        .NCELL(NCELL),
        .CNT_W(CNT_W)
    ) u_merge (
        .vcnt_i    (vt_max),
        .ireq_i    (ireq_i),
        .ireq_sat_o(ireq_sat),
        .min_o     (merged)
    );

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (!trip_i) begin
                st_d.vt   = '0;
                st_d.cnt  = '0;
                st_d.mode = MODE_IDLE;
            end else if (st_q.mode == MODE_CURR) begin
                st_d.cnt = ireq_sat;
            end else begin
                st_d.vt   = vt_max;
                st_d.cnt  = merged;
                st_d.mode = (vt_max == FULL) ? MODE_CURR : MODE_VOLT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vt   <= '0;
            st_q.cnt  <= '0;
            st_q.mode <= MODE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cells_o = st_q.cnt;
    assign mode_o  = st_q.mode;

endmodule

// File: rtl/arr_vtrack_ctl_chk.sv
module arr_vtrack_ctl_chk #(
    parameter int NCELL  = 8,
    localparam int CNT_W = $clog2(NCELL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             trip_i,
    input logic [CNT_W-1:0] ireq_i,
    input logic [CNT_W-1:0] cells_o,
    input logic [1:0]       mode_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(NCELL);

    // R5
    a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cells_o <= FULL);

    // R2
    a_r2_idle_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !trip_i) |=> (cells_o == '0 && mode_o == 2'd0));

    // R9
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(cells_o) && $stable(mode_o)));

    // R8
    a_r8_curr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && tick_i && trip_i) |=> mode_o == 2'd2);

    // R8
    a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

    // R6
    a_r6_bounded_by_request: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && trip_i) |=>
            cells_o <= (($past(ireq_i) > FULL) ? FULL : $past(ireq_i)));

    // R7
    a_r7_no_drop_full_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && tick_i && trip_i && ireq_i >= FULL) |=>
            cells_o >= $past(cells_o));

endmodule

bind arr_vtrack_ctl arr_vtrack_ctl_chk #(
    .NCELL(NCELL)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .trip_i (trip_i),
    .ireq_i (ireq_i),
    .cells_o(cells_o),
    .mode_o (mode_o)
);

// File: tb/arr_vtrack_ctl_tb_top.sv
module arr_vtrack_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCELL      = 8;
    localparam int CNT_W      = 4;
    localparam int POS_W      = 12;
    localparam int CV_W       = 16;
    localparam int OVL        = 1000;
    localparam int BRK        = 500;
    localparam int MNUM       = 4;
    localparam int MDEN       = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             trip = 1'b0;
    logic [POS_W-1:0] pos = '0;
    logic [CV_W-1:0]  cv = '0;
    logic [CNT_W-1:0] ireq = '0;
    logic [CNT_W-1:0] cells;
    logic [1:0]       mode;

    typedef struct {
        int    cells;
        int    mode;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    int   m_vt   = 0;
    int   m_mode = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    arr_vtrack_ctl dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .trip_i  (trip),
        .pos_i   (pos),
        .cell_v_i(cv),
        .ireq_i  (ireq),
        .cells_o (cells),
        .mode_o  (mode)
    );

    task automatic check(string tag, int act_c, int exp_c, int act_m, int exp_m);
        checks++;
        if (act_c != exp_c || act_m != exp_m) begin
            fails++;
            $display("FAIL %s cells=%0d expected %0d mode=%0d expected %0d",
                     tag, act_c, exp_c, act_m, exp_m);
        end
    endtask

    // Rounded withstand level from the requirement formula (R3, R4, R5, R10).
    function automatic int level_of(int p, int v);
        longint sep, x, y, r;
        sep = 2 * longint'(p) - OVL;
        if (sep < 0) sep = 0;
        if (v == 0) return NCELL;
        x = sep * BRK * MNUM;
        y = longint'(v) * 1000 * MDEN;
        r = (2 * x + y) / (2 * y);
        return (r > NCELL) ? NCELL : int'(r);
    endfunction

    task automatic step(int p, int v, int ir, bit tr, string tag);
        int irs, c, l;
        @(negedge clk);
        irs = (ir > NCELL) ? NCELL : ir;
        if (!tr) begin
            m_vt = 0; m_mode = 0; c = 0;
        end else if (m_mode == 2) begin
            c = irs;
        end else begin
            l = level_of(p, v);
            if (l > m_vt) m_vt = l;
            c = (m_vt < irs) ? m_vt : irs;
            m_mode = (m_vt == NCELL) ? 2 : 1;
        end
        q.push_back('{c, m_mode, tag});
        pos  = POS_W'(p);
        cv   = CV_W'(v);
        ireq = CNT_W'(ir);
        trip = tr;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Monitor: pops expected item for every registered tick.
    initial begin
        forever begin
            @(posedge clk);
            if (tick) begin
                #(CLK_PERIOD / 4);
                if (q.size() == 0) begin
                    check("monitor queue empty", int'(cells), -1, int'(mode), -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.tag, int'(cells), e.cells, int'(mode), e.mode);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c0, m0;
        repeat (4) @(negedge clk);
        check("R1 reset state", int'(cells), 0, int'(mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset release", int'(cells), 0, int'(mode), 0);

        step(1500, 100, 8, 1'b0, "R2 no trip holds zero");
        step(400, 100, 8, 1'b1, "R3 negative gap clamps, R8 enter voltage");
        step(500, 100, 8, 1'b1, "R3 zero gap");
        step(624, 200, 8, 1'b1, "R4 just below half level");
        step(625, 200, 8, 1'b1, "R4 exact half rounds up");
        step(1000, 100, 8, 1'b1, "R4 four cells");
        step(900, 100, 8, 1'b1, "R7 shrinking gap keeps count");
        step(1100, 100, 2, 1'b1, "R6 request below voltage count");
        step(1100, 100, 3, 1'b1, "R6 request changes");
        step(1100, 100, 15, 1'b1, "R6 oversized request saturates");

        // R9: inputs move without a tick, outputs must hold
        @(negedge clk);
        c0 = int'(cells);
        m0 = int'(mode);
        pos  = 12'd1500;
        ireq = 4'd0;
        trip = 1'b0;
        cv   = 16'd7;
        repeat (5) @(negedge clk);
        check("R9 hold without tick", int'(cells), c0, int'(mode), m0);

        step(1500, 100, 12, 1'b1, "R5 R8 full count enters current mode");
        step(0, 100, 3, 1'b1, "R8 current mode follows request");
        step(0, 100, 6, 1'b1, "R8 current mode stays");
        step(0, 100, 6, 1'b0, "R2 trip release returns idle");
        step(0, 0, 8, 1'b1, "R10 zero cell estimate gives full");
        step(0, 0, 8, 1'b0, "R2 release again");
        step(4000, 50, 15, 1'b1, "R5 large gap capped at cell count");
        step(4000, 50, 1, 1'b1, "R8 current mode low request");

        wait (q.size() == 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule